// File: doc/BRIEF.md
# Arithmetic Unit with Stored Status Flags and Condition Test

This block is the execute-stage arithmetic unit of a small 32-bit processor. It has four operations: add, subtract, bitwise AND and bitwise exclusive-OR. A 4-bit operation code selects the operation, and the result is combinational. Three status flags are held in registers: zero, negative and signed overflow. An arithmetic or logic instruction raises the flag-write enable, and the flags then take their new values from the result at the next clock edge.

A separate 4-bit test code selects one of seven tests on the stored flags. The output says whether the test passes. Conditional register moves and conditional branches both use this output. Test code 0 always passes, so it serves as the plain move and the plain jump. Operation codes and test codes outside the defined ranges are reported on their own error outputs and have no other effect.

Top module: `cc_alu`

## Requirements
- R1: With op code 0 the result is `opnd_a + opnd_b`, truncated to 32 bits.
- R2: With op code 1 the result is `opnd_b - opnd_a`, truncated to 32 bits.
- R3: With op code 2 the result is `opnd_a & opnd_b`. With op code 3 it is `opnd_a ^ opnd_b`.
- R4: When `flag_we` is 1 and the op code is valid, the next rising clock edge loads the flags as follows.
  - `zf` is 1 when the result is zero.
  - `sf` is 1 when bit 31 of the result is 1.
  - For add, `of` is 1 when both operands have the same sign and the result's sign differs from it.
  - For subtract, `of` is 1 when the operand signs differ and the result's sign differs from `opnd_b`.
  - For AND and XOR, `of` is 0.
- R5: When `flag_we` is 0, `zf`, `sf` and `of` keep their values across the clock edge.
- R6: At a clock edge with `rst` high, the flags become `zf`=1, `sf`=0, `of`=0.
- R7: `cond_true` is computed combinationally from the stored flags, writing lt for `sf ^ of`. The test codes are:
  - code 1: lt | `zf`
  - code 2: lt
  - code 3: `zf`
  - code 4: !`zf`
  - code 5: !lt
  - code 6: !lt & !`zf`
- R8: Test code 0 always gives `cond_true` = 1, whatever the flags are.
- R9: With op codes 4 to 15, `op_bad` is 1 and `result` is 0. The flags do not change at the next edge, even when `flag_we` is 1. For valid op codes `op_bad` is 0.
- R10: With test codes 7 to 15, `cond_bad` is 1 and `cond_true` is 0. For codes 0 to 6 `cond_bad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_fn | input | 4 | Operation code (0 add, 1 subtract, 2 AND, 3 XOR) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand; subtract computes this minus `opnd_a` |
| flag_we | input | 1 | Load the flags from this operation at the next edge |
| cond_fn | input | 4 | Test code, 0 to 6 |
| result | output | 32 | Operation result |
| zf | output | 1 | Stored zero flag |
| sf | output | 1 | Stored negative flag |
| of | output | 1 | Stored signed-overflow flag |
| cond_true | output | 1 | Selected test passes on the stored flags |
| op_bad | output | 1 | Operation code out of range |
| cond_bad | output | 1 | Test code out of range |

## Verification
The assertions assume that every input is a known value at each sampled edge. They also assume that `flag_we` may be combined with any op code, including invalid ones. The stimulus drives every input from time zero and changes inputs only at the falling edge. It covers the whole 4-bit range of both codes, so the out-of-range paths are exercised under the same assumptions as the legal ones. The operand mix includes zeros, equal operands and the signed extremes, so that every flag and every test outcome occurs.

// File: rtl/cc_alu_pkg.sv
`timescale 1ns/1ps
package cc_alu_pkg;
  localparam int FN_W      = 4;
  localparam int NUM_OPS   = 4;
  localparam int NUM_TESTS = 7;

  typedef enum logic [FN_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_XOR = 4'd3
  } alu_op_e;

  typedef enum logic [FN_W-1:0] {
    TST_ALWAYS = 4'd0,
    TST_LE     = 4'd1,
    TST_LT     = 4'd2,
    TST_EQ     = 4'd3,
    TST_NE     = 4'd4,
    TST_GE     = 4'd5,
    TST_GT     = 4'd6
  } test_e;

  typedef struct packed {
    logic z;
    logic s;
    logic o;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{z: 1'b1, s: 1'b0, o: 1'b0};
endpackage

// File: rtl/cc_alu_arith.sv
`timescale 1ns/1ps
module cc_alu_arith
  import cc_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [FN_W-1:0]  fn,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res,
  output flags_t           nxt,
  output logic             bad
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] diff;
  logic             ovf;

  assign sum  = a + b;
  assign diff = b - a;

  always_comb begin
    res = '0;
    ovf = 1'b0;
    bad = 1'b0;
    case (fn)
      OP_ADD: begin
        res = sum;
        ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      end
      OP_SUB: begin
        res = diff;
        ovf = (a[MSB] != b[MSB]) && (diff[MSB] != b[MSB]);
      end
      OP_AND: res = a & b;
      OP_XOR: res = a ^ b;
      default: bad = 1'b1;
    endcase
  end

  assign nxt.z = (res == '0);
  assign nxt.s = res[MSB];
  assign nxt.o = ovf;
endmodule

// File: rtl/cc_alu_flags.sv
`timescale 1ns/1ps
module cc_alu_flags
  import cc_alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= FLAGS_RESET;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/cc_alu_test.sv
`timescale 1ns/1ps
module cc_alu_test
  import cc_alu_pkg::*;
(
  input  logic [FN_W-1:0] fn,
  input  flags_t          f,
  output logic            pass,
  output logic            bad
);
  localparam int SEL_W = $clog2(NUM_TESTS);

  logic                 lt;
  logic [NUM_TESTS-1:0] hit;

  assign lt = f.s ^ f.o;

  for (genvar i = 0; i < NUM_TESTS; i++) begin : g_test
    if (i == int'(TST_ALWAYS)) begin : g_always
      assign hit[i] = 1'b1;
    end else if (i == int'(TST_LE)) begin : g_le
      assign hit[i] = lt | f.z;
    end else if (i == int'(TST_LT)) begin : g_lt
      assign hit[i] = lt;
    end else if (i == int'(TST_EQ)) begin : g_eq
      assign hit[i] = f.z;
    end else if (i == int'(TST_NE)) begin : g_ne
      assign hit[i] = ~f.z;
    end else if (i == int'(TST_GE)) begin : g_ge
      assign hit[i] = ~lt;
    end else begin : g_gt
      assign hit[i] = ~lt & ~f.z;
    end
  end

  assign bad  = (fn >= FN_W'(NUM_TESTS));
  assign pass = bad ? 1'b0 : hit[fn[SEL_W-1:0]];
endmodule

// File: rtl/cc_alu.sv
`timescale 1ns/1ps
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_fn,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             flag_we,
  input  logic [3:0]       cond_fn,
  output logic [WIDTH-1:0] result,
  output logic             zf,
  output logic             sf,
  output logic             of,
  output logic             cond_true,
  output logic             op_bad,
  output logic             cond_bad
);
  flags_t nxt_flags;
  flags_t cur_flags;

  cc_alu_arith #(.WIDTH(WIDTH)) arith_i (
    .fn  (op_fn),
    .a   (opnd_a),
    .b   (opnd_b),
    .res (result),
    .nxt (nxt_flags),
    .bad (op_bad)
  );

  cc_alu_flags flags_i (
    .clk  (clk),
    .rst  (rst),
    .load (flag_we & ~op_bad),
    .d    (nxt_flags),
    .q    (cur_flags)
  );

  cc_alu_test test_i (
    .fn   (cond_fn),
    .f    (cur_flags),
    .pass (cond_true),
    .bad  (cond_bad)
  );

  assign zf = cur_flags.z;
  assign sf = cur_flags.s;
  assign of = cur_flags.o;
endmodule

// File: rtl/cc_alu_chk.sv
`timescale 1ns/1ps
module cc_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op_fn,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic             flag_we,
  input logic [3:0]       cond_fn,
  input logic [WIDTH-1:0] result,
  input logic             zf,
  input logic             sf,
  input logic             of,
  input logic             cond_true,
  input logic             op_bad,
  input logic             cond_bad
);
  AST_SUB_ORDER: assert property (@(posedge clk) disable iff (rst)
    (op_fn == 4'd1) |-> (result == opnd_b - opnd_a)); // R2
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (flag_we && !op_bad) |=> (zf == ($past(result) == '0))); // R4
  AST_LOGIC_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (flag_we && (op_fn == 4'd2 || op_fn == 4'd3)) |=> !of); // R4
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable({zf, sf, of})); // R5
  AST_EQ_TEST: assert property (@(posedge clk) disable iff (rst)
    (cond_fn == 4'd3) |-> (cond_true == zf)); // R7
  AST_ALWAYS_PASS: assert property (@(posedge clk) disable iff (rst)
    (cond_fn == 4'd0) |-> cond_true); // R8
  AST_BAD_OP: assert property (@(posedge clk) disable iff (rst)
    (op_fn >= 4'd4) |=> (op_bad || $past(op_bad)) && $stable({zf, sf, of})); // R9
  AST_BAD_TEST: assert property (@(posedge clk) disable iff (rst)
    (cond_fn >= 4'd7) |-> (cond_bad && !cond_true)); // R10
endmodule

bind cc_alu cc_alu_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .op_fn(op_fn), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .flag_we(flag_we), .cond_fn(cond_fn), .result(result), .zf(zf), .sf(sf),
  .of(of), .cond_true(cond_true), .op_bad(op_bad), .cond_bad(cond_bad)
);

// File: tb/cc_alu_tb_top.sv
`timescale 1ns/1ps
module cc_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_fn = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        flag_we = 1'b0;
  logic [3:0]  cond_fn = '0;
  logic [31:0] result;
  logic        zf, sf, of, cond_true, op_bad, cond_bad;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference flag state
  bit mz = 1, ms = 0, mo = 0;

  always #4 clk = ~clk;

  cc_alu dut_i (
    .clk(clk), .rst(rst), .op_fn(op_fn), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .flag_we(flag_we), .cond_fn(cond_fn), .result(result), .zf(zf), .sf(sf),
    .of(of), .cond_true(cond_true), .op_bad(op_bad), .cond_bad(cond_bad)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Behavioural model of one operation.
  task automatic model_op(input int fn, input bit [31:0] a, input bit [31:0] b,
                          output bit [31:0] r, output bit z, output bit s,
                          output bit o, output bit inv);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint wide = 0;
    inv = 0; o = 0; r = 0;
    case (fn)
      0: begin wide = sa + sb; r = a + b; end
      1: begin wide = sb - sa; r = b - a; end
      2: r = a & b;
      3: r = a ^ b;
      default: inv = 1;
    endcase
    if (fn == 0 || fn == 1) o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
    z = (r == 0);
    s = r[31];
  endtask

  function automatic bit model_test(int fn, bit z, bit s, bit o);
    bit lt = (s != o);
    case (fn)
      0: return 1;
      1: return lt || z;
      2: return lt;
      3: return z;
      4: return !z;
      5: return !lt;
      6: return !lt && !z;
      default: return 0;
    endcase
  endfunction

  task automatic step(int fn, bit [31:0] a, bit [31:0] b, bit we, int cfn);
    bit [31:0] er;
    bit ez, es, eo, einv;
    string rtag;
    string ctag;
    op_fn = 4'(fn); opnd_a = a; opnd_b = b; flag_we = we; cond_fn = 4'(cfn);
    #1;
    model_op(fn, a, b, er, ez, es, eo, einv);
    case (fn)
      0: rtag = "R1 add result";
      1: rtag = "R2 sub result";
      2, 3: rtag = "R3 logic result";
      default: rtag = "R9 invalid op result";
    endcase
    check(rtag, result, er);
    check("R9 op_bad", 32'(op_bad), 32'(einv));
    check("R4/R5 flags", {29'd0, zf, sf, of}, {29'd0, mz, ms, mo});
    if (cfn == 0) ctag = "R8 always test";
    else if (cfn >= 7) ctag = "R10 invalid test";
    else ctag = "R7 test outcome";
    check(ctag, 32'(cond_true), 32'(model_test(cfn, mz, ms, mo)));
    check("R10 cond_bad", 32'(cond_bad), 32'(cfn >= 7));
    @(posedge clk);
    if (rst) begin mz = 1; ms = 0; mo = 0; end
    else if (we && !einv) begin mz = ez; ms = es; mo = eo; end
    @(negedge clk);
  endtask

  function automatic bit [31:0] pick_opnd();
    case ($urandom % 6)
      0: return 32'h0;
      1: return 32'h7fffffff;
      2: return 32'h80000000;
      3: return 32'hffffffff;
      4: return 32'h1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    @(negedge clk);
    step(0, 32'h5, 32'h9, 1, 0);  // held in reset
    rst = 0;
    check("R6 reset flags", {29'd0, zf, sf, of}, 32'b100);
    // reset flags against every test code
    for (int c = 0; c < 16; c++) step(2, 32'h0, 32'h0, 0, c);
    // add overflow: 0x7fffffff + 1
    step(0, 32'h7fffffff, 32'h1, 1, 0);
    for (int c = 0; c < 8; c++) step(3, 32'h1, 32'h1, 0, c);
    // sub overflow: 0x80000000 - 1
    step(1, 32'h1, 32'h80000000, 1, 2);
    step(1, 32'h3, 32'h3, 1, 6);   // equal -> zero
    step(2, 32'hf0f0f0f0, 32'hff00ff00, 0, 3);  // R5 hold
    step(3, 32'habcd1234, 32'habcd1234, 1, 3);
    step(5, 32'h1, 32'h2, 1, 3);   // R9 invalid op with write enable
    step(15, 32'hffffffff, 32'h1, 1, 4);
    step(1, 32'h5, 32'h2, 1, 1);   // 2 - 5 negative
    for (int c = 0; c < 8; c++) step(0, 32'h0, 32'h0, 0, c);
    for (int i = 0; i < 3000; i++) begin
      int fn = ($urandom % 5 == 4) ? int'(4 + $urandom % 12) : int'($urandom % 4);
      int cf = ($urandom % 9 >= 7) ? int'(7 + $urandom % 9) : int'($urandom % 7);
      bit [31:0] a = pick_opnd();
      bit [31:0] b = ($urandom % 8 == 0) ? a : pick_opnd();
      step(fn, a, b, bit'($urandom % 3 != 0), cf);
    end
    rst = 1;
    step(0, 32'h80000000, 32'h80000000, 1, 0);
    rst = 0;
    check("R6 reset flags after run", {29'd0, zf, sf, of}, 32'b100);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule